// File: doc/BRIEF.md
# Teletext Packet Buffer with Host Access Control

This block sits between a teletext slicer and its consumers. It is a byte-wide first-in first-out buffer. It counts whole transactions as they arrive, and it hands bytes either to a host register port or to a downstream output formatter. A single control word decides which reader is served. The same word also starts a self-clearing flush, switches the buffer into a diagnostic mode where host test bytes replace slicer data, and chooses how the data-ready flag is qualified.

A transaction is a fixed run of `PKT_LEN` bytes. The write side raises the count of complete transactions when it stores the last byte of one. The read side lowers that count when it pops the last byte of one. A read-in-progress status shows that a transaction has been partly consumed. Two status flags are available. One compares the fill level with a programmable threshold. The other reports buffered packets, but only on the video line chosen by an interrupt-line value. Everything runs on one clock with a synchronous active-high reset.

Top module: `ttx_fifo_controller`

## Requirements
- R1: A control write with bit 0 set raises `flushActive` on the next cycle. On the edge after that, `fillLevel`, `pktCount`, `readInProgress` and `overflow` all become 0, `flushActive` returns to 0, and any push or pop presented in the flush cycle is ignored.
- R2: Control bit 1 (host read enable, reset value 1) selects the reader. When it is 1, `hostData`/`hostPop` are served and `fmtData` reads 0 while `fmtPop` is ignored. When it is 0, the roles are swapped.
- R3: Control bit 2 (test mode, reset value 0) makes `testWe`/`testData` the only write source and discards slicer bytes. When it is 0, `testWe` is ignored.
- R4: Bytes are read back in the order they were written, whichever write source was used.
- R5: `readInProgress` is 1 after the first byte of a transaction has been popped and returns to 0 when that transaction's last byte (byte `PKT_LEN`) is popped.
- R6: `pktCount` rises by one when the `PKT_LEN`-th byte of a transaction is stored and falls by one when the last byte of a transaction is popped.
- R7: `thrFlag` is 1 exactly when `fillLevel >= thrLevel`.
- R8: With control bit 3 at 0, `dataFlag` is 1 exactly when `videoLine == irqLine` and `pktCount` is non-zero.
- R9: With control bit 3 at 1, `dataFlag` is 1 whenever `videoLine == irqLine`, even with no data buffered.
- R10: A write while `fillLevel == DEPTH` is dropped and sets a sticky `overflow` bit that only a flush or reset clears. Dropped bytes do not count toward a transaction.
- R11: When the buffer is empty, both data outputs read 0x00 and a pop changes no state.
- R12: After reset the level, packet count, flags, overflow and read-in-progress are 0, host read enable is 1 and test mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctlWe | input | 1 | Control word write strobe |
| ctlWdata | input | 4 | Control word: bit0 flush, bit1 host read enable, bit2 test mode, bit3 line-only data flag |
| slicerValid | input | 1 | Slicer byte valid |
| slicerData | input | 8 | Slicer byte |
| testWe | input | 1 | Host test byte write strobe |
| testData | input | 8 | Host test byte |
| hostPop | input | 1 | Host pop request |
| fmtPop | input | 1 | Output formatter pop request |
| thrLevel | input | CNT_W | Fill threshold |
| videoLine | input | LINE_W | Current video line |
| irqLine | input | LINE_W | Interrupt line number |
| hostData | output | 8 | Head byte for the host port |
| fmtData | output | 8 | Head byte for the formatter |
| fillLevel | output | CNT_W | Bytes buffered |
| pktCount | output | CNT_W | Complete transactions buffered |
| thrFlag | output | 1 | Fill level at or above threshold |
| dataFlag | output | 1 | Data-ready flag on the matching line |
| overflow | output | 1 | Sticky write-drop indicator |
| readInProgress | output | 1 | Transaction partly read |
| flushActive | output | 1 | Flush bit readback, self-clearing |
| hostReadEn | output | 1 | Host read enable readback |
| ramTestMode | output | 1 | Test mode readback |
| lineAnyMode | output | 1 | Line-only data flag mode readback |

## Verification
The assertions assume that the control word is not written with the flush bit on two cycles in a row, so the self-clearing check always sees a quiet cycle after each flush. They also assume that `thrLevel`, `videoLine` and `irqLine` change only between clock edges. The bench writes every control word through one task that is followed by at least one idle cycle, and it changes the line and threshold inputs only in the settle time after an edge. Both write sources are exercised, but they are never driven in a way that relies on any mixing beyond what R3 defines.

// File: rtl/ttx_fifo_pkg.sv
package ttx_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W = 4;
  localparam int CTL_FLUSH = 0;
  localparam int CTL_HOST_RD = 1;
  localparam int CTL_RAM_TEST = 2;
  localparam int CTL_LINE_ANY = 3;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic              flush;
    logic              push;
    logic [BYTE_W-1:0] pushByte;
    logic              pop;
  } fifoStrobe_t;
endpackage

// File: rtl/ttx_fifo_ctrl_unit.sv
module ttx_fifo_ctrl_unit
  import ttx_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctlWe,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  logic              slicerValid,
  input  logic [BYTE_W-1:0] slicerData,
  input  logic              testWe,
  input  logic [BYTE_W-1:0] testData,
  input  logic              hostPop,
  input  logic              fmtPop,
  input  logic              fifoEmpty,
  output fifoStrobe_t       strobe,
  output logic              flushActive,
  output logic              hostReadEn,
  output logic              ramTestMode,
  output logic              lineAnyMode
);
  logic flushReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      flushReg    <= 1'b0;
      hostReadEn  <= 1'b1;
      ramTestMode <= 1'b0;
      lineAnyMode <= 1'b0;
    end else begin
      // the flush bit lives one cycle only
      flushReg <= ctlWe && ctlWdata[CTL_FLUSH];
      if (ctlWe) begin
        hostReadEn  <= ctlWdata[CTL_HOST_RD];
        ramTestMode <= ctlWdata[CTL_RAM_TEST];
        lineAnyMode <= ctlWdata[CTL_LINE_ANY];
      end
    end
  end

  always_comb begin
    strobe.flush    = flushReg;
    strobe.push     = !flushReg && (ramTestMode ? testWe : slicerValid);
    strobe.pushByte = ramTestMode ? testData : slicerData;
    strobe.pop      = !flushReg && !fifoEmpty && (hostReadEn ? hostPop : fmtPop);
  end

  assign flushActive = flushReg;
endmodule

// File: rtl/ttx_fifo_datapath.sv
module ttx_fifo_datapath
  import ttx_fifo_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int PKT_LEN = 42,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       strobe,
  output logic [BYTE_W-1:0] rdByte,
  output logic [CNT_W-1:0]  fillLevel,
  output logic [CNT_W-1:0]  pktCount,
  output logic              readInProgress,
  output logic              overflow,
  output logic              fifoEmpty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int POS_W = $clog2(PKT_LEN);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [POS_W-1:0]  wrPos, rdPos;
  logic fifoFull, doPush, doPop, wrLast, rdLast;

  assign fifoFull  = (fillLevel == FULL_LVL);
  assign fifoEmpty = (fillLevel == '0);
  assign doPush    = strobe.push && !fifoFull;
  assign doPop     = strobe.pop && !fifoEmpty;
  assign wrLast    = doPush && (wrPos == LAST_POS);
  assign rdLast    = doPop && (rdPos == LAST_POS);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [POS_W-1:0] nextPos(input logic [POS_W-1:0] p);
    return (p == LAST_POS) ? '0 : p + POS_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= strobe.pushByte;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      wrPos     <= '0;
      rdPos     <= '0;
      fillLevel <= '0;
      pktCount  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (doPush) begin
        wrPtr <= nextPtr(wrPtr);
        wrPos <= nextPos(wrPos);
      end
      if (doPop) begin
        rdPtr <= nextPtr(rdPtr);
        rdPos <= nextPos(rdPos);
      end
      case ({doPush, doPop})
        2'b10:   fillLevel <= fillLevel + CNT_W'(1);
        2'b01:   fillLevel <= fillLevel - CNT_W'(1);
        default: fillLevel <= fillLevel;
      endcase
      case ({wrLast, rdLast})
        2'b10:   pktCount <= pktCount + CNT_W'(1);
        2'b01:   pktCount <= pktCount - CNT_W'(1);
        default: pktCount <= pktCount;
      endcase
      if (strobe.push && fifoFull) overflow <= 1'b1;
    end
  end

  assign rdByte         = fifoEmpty ? '0 : mem[rdPtr];
  assign readInProgress = (rdPos != '0);
endmodule

// File: rtl/ttx_fifo_controller.sv
module ttx_fifo_controller
  import ttx_fifo_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int PKT_LEN = 42,
  parameter int LINE_W  = 9,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctlWe,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  logic              slicerValid,
  input  logic [BYTE_W-1:0] slicerData,
  input  logic              testWe,
  input  logic [BYTE_W-1:0] testData,
  input  logic              hostPop,
  input  logic              fmtPop,
  input  logic [CNT_W-1:0]  thrLevel,
  input  logic [LINE_W-1:0] videoLine,
  input  logic [LINE_W-1:0] irqLine,
  output logic [BYTE_W-1:0] hostData,
  output logic [BYTE_W-1:0] fmtData,
  output logic [CNT_W-1:0]  fillLevel,
  output logic [CNT_W-1:0]  pktCount,
  output logic              thrFlag,
  output logic              dataFlag,
  output logic              overflow,
  output logic              readInProgress,
  output logic              flushActive,
  output logic              hostReadEn,
  output logic              ramTestMode,
  output logic              lineAnyMode
);
  fifoStrobe_t       strobe;
  logic [BYTE_W-1:0] rdByte;
  logic              fifoEmpty;

  ttx_fifo_ctrl_unit u_ctrl (
    .clk(clk), .rst(rst), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .slicerValid(slicerValid), .slicerData(slicerData),
    .testWe(testWe), .testData(testData),
    .hostPop(hostPop), .fmtPop(fmtPop), .fifoEmpty(fifoEmpty),
    .strobe(strobe), .flushActive(flushActive), .hostReadEn(hostReadEn),
    .ramTestMode(ramTestMode), .lineAnyMode(lineAnyMode)
  );

  ttx_fifo_datapath #(.DEPTH(DEPTH), .PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdByte(rdByte),
    .fillLevel(fillLevel), .pktCount(pktCount),
    .readInProgress(readInProgress), .overflow(overflow), .fifoEmpty(fifoEmpty)
  );

  assign hostData = hostReadEn ? rdByte : '0;
  assign fmtData  = hostReadEn ? '0 : rdByte;
  assign thrFlag  = (fillLevel >= thrLevel);
  assign dataFlag = (videoLine == irqLine) && (lineAnyMode || (pktCount != '0));
endmodule

// File: rtl/ttx_fifo_checker.sv
module ttx_fifo_checker
  import ttx_fifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LINE_W = 9,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ctlWe,
  input logic [CTL_W-1:0]  ctlWdata,
  input logic              hostPop,
  input logic              fmtPop,
  input logic [LINE_W-1:0] videoLine,
  input logic [LINE_W-1:0] irqLine,
  input logic [CNT_W-1:0]  fillLevel,
  input logic [CNT_W-1:0]  pktCount,
  input logic              overflow,
  input logic              readInProgress,
  input logic              flushActive,
  input logic              hostReadEn,
  input logic [BYTE_W-1:0] hostData,
  input logic [BYTE_W-1:0] fmtData,
  input logic              dataFlag
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  a_r1_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flushActive |=> (fillLevel == '0 && pktCount == '0 && !overflow && !readInProgress));

  a_r1_flush_self_clear: assert property (@(posedge clk) disable iff (rst)
    (flushActive && !(ctlWe && ctlWdata[CTL_FLUSH])) |=> !flushActive);

  a_r2_host_route: assert property (@(posedge clk) disable iff (rst)
    hostReadEn |-> fmtData == '0);

  a_r2_fmt_route: assert property (@(posedge clk) disable iff (rst)
    !hostReadEn |-> hostData == '0);

  a_r8_line_match: assert property (@(posedge clk) disable iff (rst)
    dataFlag |-> videoLine == irqLine);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !flushActive) |=> overflow);

  a_r10_no_overfill: assert property (@(posedge clk) disable iff (rst)
    fillLevel <= FULL_LVL);

  a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
    (fillLevel == FULL_LVL && !hostPop && !fmtPop && !flushActive) |=> fillLevel == FULL_LVL);

  a_r11_empty_zero: assert property (@(posedge clk) disable iff (rst)
    fillLevel == '0 |-> (hostData == '0 && fmtData == '0));

  a_r6_pkt_bound: assert property (@(posedge clk) disable iff (rst)
    pktCount <= fillLevel);
endmodule

bind ttx_fifo_controller ttx_fifo_checker #(.DEPTH(DEPTH), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
  .hostPop(hostPop), .fmtPop(fmtPop), .videoLine(videoLine), .irqLine(irqLine),
  .fillLevel(fillLevel), .pktCount(pktCount), .overflow(overflow),
  .readInProgress(readInProgress), .flushActive(flushActive), .hostReadEn(hostReadEn),
  .hostData(hostData), .fmtData(fmtData), .dataFlag(dataFlag)
);

// File: tb/ttx_fifo_controller_bench.sv
`timescale 1ns/1ps
module ttx_fifo_controller_bench;
  localparam int DEPTH = 8;
  localparam int PKT_LEN = 3;
  localparam int LINE_W = 9;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctlWe = 1'b0;
  logic [3:0] ctlWdata = '0;
  logic slicerValid = 1'b0;
  logic [7:0] slicerData = '0;
  logic testWe = 1'b0;
  logic [7:0] testData = '0;
  logic hostPop = 1'b0;
  logic fmtPop = 1'b0;
  logic [CNT_W-1:0] thrLevel = 4'd5;
  logic [LINE_W-1:0] videoLine = 9'd1;
  logic [LINE_W-1:0] irqLine = 9'd10;
  logic [7:0] hostData, fmtData;
  logic [CNT_W-1:0] fillLevel, pktCount;
  logic thrFlag, dataFlag, overflow, readInProgress, flushActive;
  logic hostReadEn, ramTestMode, lineAnyMode;

  int total = 0;
  int failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ttx_fifo_controller #(.DEPTH(DEPTH), .PKT_LEN(PKT_LEN), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_ttx_fifo_controller (
    .clk(clk), .rst(rst), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .slicerValid(slicerValid), .slicerData(slicerData),
    .testWe(testWe), .testData(testData), .hostPop(hostPop), .fmtPop(fmtPop),
    .thrLevel(thrLevel), .videoLine(videoLine), .irqLine(irqLine),
    .hostData(hostData), .fmtData(fmtData), .fillLevel(fillLevel), .pktCount(pktCount),
    .thrFlag(thrFlag), .dataFlag(dataFlag), .overflow(overflow),
    .readInProgress(readInProgress), .flushActive(flushActive),
    .hostReadEn(hostReadEn), .ramTestMode(ramTestMode), .lineAnyMode(lineAnyMode)
  );

  // op: 0 slicer push, 1 host pop (data = expected head), 2 test write
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic [3:0] fill;
    logic [3:0] pkt;
    logic       rip;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{2'd0, 8'hA0, 4'd1, 4'd0, 1'b0},
    '{2'd0, 8'hA1, 4'd2, 4'd0, 1'b0},
    '{2'd0, 8'hA2, 4'd3, 4'd1, 1'b0},
    '{2'd0, 8'hB0, 4'd4, 4'd1, 1'b0},
    '{2'd1, 8'hA0, 4'd3, 4'd1, 1'b1},
    '{2'd2, 8'h55, 4'd3, 4'd1, 1'b1},
    '{2'd1, 8'hA1, 4'd2, 4'd1, 1'b1},
    '{2'd1, 8'hA2, 4'd1, 4'd0, 1'b0},
    '{2'd1, 8'hB0, 4'd0, 4'd0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ctlWe = 0; slicerValid = 0; testWe = 0; hostPop = 0; fmtPop = 0;
  endtask

  task automatic ctlWrite(input logic [3:0] v);
    ctlWe = 1; ctlWdata = v;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R12 reset state
    chk("R12 fill", fillLevel, 0);
    chk("R12 pkt", pktCount, 0);
    chk("R12 hostReadEn", hostReadEn, 1);
    chk("R12 ramTest", ramTestMode, 0);
    chk("R12 flags", {thrFlag, dataFlag, overflow, readInProgress, flushActive}, 0);
    chk("R11 empty data", hostData, 0);

    // table walk: R4 order, R5 read-in-progress, R6 packet count, R3 test write ignored
    foreach (VEC[i]) begin
      case (VEC[i].op)
        2'd0: begin slicerValid = 1; slicerData = VEC[i].data; end
        2'd1: begin
          chk("R4 head byte", hostData, VEC[i].data);
          hostPop = 1;
        end
        default: begin testWe = 1; testData = VEC[i].data; end
      endcase
      step();
      chk("R3/R4 fill", fillLevel, VEC[i].fill);
      chk("R6 pktCount", pktCount, VEC[i].pkt);
      chk("R5 readInProgress", readInProgress, VEC[i].rip);
    end

    // R11 pop on empty
    hostPop = 1;
    step();
    chk("R11 empty pop fill", fillLevel, 0);
    chk("R11 empty pop rip", readInProgress, 1);
    chk("R11 empty data", hostData, 0);

    // R1 flush
    ctlWrite(4'b0011);
    chk("R1 flushActive set", flushActive, 1);
    step();
    chk("R1 flushActive clear", flushActive, 0);
    chk("R1 rip cleared", readInProgress, 0);

    // R10 overflow, R7 threshold
    thrLevel = 4'd5;
    for (int i = 0; i < 10; i++) begin
      slicerValid = 1; slicerData = 8'h10 + 8'(i);
      step();
      if (i == 3) chk("R7 below threshold", thrFlag, 0);
      if (i == 4) chk("R7 at threshold", thrFlag, 1);
    end
    chk("R10 fill full", fillLevel, 8);
    chk("R10 overflow", overflow, 1);
    chk("R10 pkt after drop", pktCount, 2);
    thrLevel = 4'd9;
    #1 chk("R7 above level", thrFlag, 0);

    // R8 data flag
    videoLine = 9'd10;
    #1 chk("R8 match with data", dataFlag, 1);
    videoLine = 9'd11;
    #1 chk("R8 no match", dataFlag, 0);

    // R2 routing to formatter
    ctlWrite(4'b0000);
    chk("R2 host blocked", hostData, 0);
    chk("R2 fmt head", fmtData, 8'h10);
    hostPop = 1;
    step();
    chk("R2 host pop ignored", fillLevel, 8);
    fmtPop = 1;
    step();
    chk("R2 fmt pop", fillLevel, 7);
    chk("R2 fmt next", fmtData, 8'h11);
    chk("R10 overflow sticky", overflow, 1);

    // R1 flush clears overflow, count and flags
    ctlWrite(4'b0011);
    fmtPop = 1; hostPop = 1;
    step();
    chk("R1 fill cleared", fillLevel, 0);
    chk("R1 overflow cleared", overflow, 0);
    chk("R1 pkt cleared", pktCount, 0);
    videoLine = 9'd10;
    #1 chk("R8 match no data", dataFlag, 0);

    // R9 line-only mode
    ctlWrite(4'b1010);
    chk("R9 line-only flag", dataFlag, 1);

    // R3 test mode
    ctlWrite(4'b0110);
    slicerValid = 1; slicerData = 8'hAA;
    step();
    chk("R3 slicer discarded", fillLevel, 0);
    testWe = 1; testData = 8'hC1;
    step();
    testWe = 1; testData = 8'hC2;
    step();
    chk("R3 test writes", fillLevel, 2);
    chk("R4 test order first", hostData, 8'hC1);
    hostPop = 1;
    step();
    chk("R4 test order second", hostData, 8'hC2);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule